// File: doc/BRIEF.md
# Bit-String Locator

This block turns a bit-string reference, made of a base and a bit offset, into the single bit it names. When the base is a register value, the block picks the bit straight out of that value. The offset is first reduced modulo the operand size. When the base is a memory address, the block works out which byte holds the bit and where the bit sits in that byte. It then raises a fetch request for that byte, waits for the byte to come back, and returns the chosen bit.

Signed register offsets may point below the base address. For these the block uses floor division for the byte displacement and a modulo that never goes negative for the bit index, not truncating arithmetic. A small controller sequences each operation through three states:

- `ST_IDLE` waits for `start`.
- `ST_FETCH` holds a memory request open.
- `ST_RESULT` presents the bit for one cycle.

The transitions are:

- `T_ACCEPT_REG`: IDLE→RESULT, when `start` arrives with a register base.
- `T_ACCEPT_MEM`: IDLE→FETCH, when `start` arrives with a memory base.
- `T_FILL`: FETCH→RESULT, when `rd_valid` arrives.
- `T_RETIRE`: RESULT→IDLE, always.
- Synchronous reset returns any state to IDLE.

Top module: `bitstr_locator`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) leaves `req_valid` and `bit_valid` low from the next cycle on, and abandons any pending fetch.
- R2: With `base_is_mem`=0, a `start` accepted in idle gives `bit_valid`=1 in the following cycle, with `bit_out` = bit (offset mod n) of `base`. Bit 0 is the least significant bit. n is 16 for `size_sel`=00, 32 for 01, and 64 for 10 or 11.
- R3: With a register base, offsets of n or more wrap. For example, offset 37 at n=32 selects bit 5.
- R4: With a memory base and `off_is_reg`=0, the offset is taken as (offset mod n), unsigned. `req_valid` rises the cycle after `start`, with `req_addr` = base + (offset mod n) / 8. The bit index is (offset mod n) mod 8.
- R5: With a memory base and `off_is_reg`=1, the low n bits of the offset are a signed value s. `req_addr` = base + floor(s/8), and the bit index is s mod 8, in the range 0 to 7. So −11 gives base−2, bit 5, and +13 gives base+1, bit 5.
- R6: `req_valid` stays high with `req_addr` unchanged until `rd_valid` is sampled high. In the next cycle `bit_valid`=1, with `bit_out` = `rd_byte` at the bit index.
- R7: A `start` that arrives while a fetch is outstanding, or during the result cycle, is ignored.
- R8: `rd_valid` while idle has no effect: no `bit_valid` and no request.
- R9: `bit_valid` is a one-cycle pulse and is never high together with `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (taken only in idle) |
| base | input | W | Register value or byte base address |
| offset | input | W | Bit offset |
| size_sel | input | 2 | Operand size: 00=16, 01=32, else 64 |
| off_is_reg | input | 1 | 1: signed register offset; 0: immediate offset |
| base_is_mem | input | 1 | 1: base is a memory address; 0: register value |
| req_valid | output | 1 | Byte fetch request outstanding |
| req_addr | output | W | Address of the byte to fetch |
| rd_valid | input | 1 | Fetched byte present |
| rd_byte | input | 8 | Fetched byte |
| bit_valid | output | 1 | Result bit valid (one cycle) |
| bit_out | output | 1 | Selected bit |

## Verification
The embedded properties check, on every cycle, that a request is held with a stable address until data arrives, and that returned data always yields a result in the next cycle. They also check that the result is a single-cycle pulse exclusive with the request, that stray read data in idle produces nothing, and that reset clears both strobes.

Only the directed scenarios can show that the address and bit values are correct. These cover modulo wrap of register offsets, masking of immediates, and floor division for negative offsets (−1, −8, −11) at several operand sizes. They also cover the extremes of the signed range and that a `start` arriving mid-fetch is dropped.

// File: rtl/bitstr_pkg.sv
package bitstr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_RESULT = 2'd2
    } bsl_state_e;

    localparam logic [1:0] SZ_16 = 2'b00;
    localparam logic [1:0] SZ_32 = 2'b01;

    // Map the size selector onto an index into the 16/32/64 candidate tables.
    function automatic logic [1:0] size_slot(input logic [1:0] sel);
        unique case (sel)
            SZ_16:   size_slot = 2'd0;
            SZ_32:   size_slot = 2'd1;
            default: size_slot = 2'd2;
        endcase
    endfunction
endpackage

// File: rtl/bitstr_offset_norm.sv
module bitstr_offset_norm #(
    parameter int W = 64
) (
    input  logic [W-1:0]         offset,
    input  logic [1:0]           size_sel,
    input  logic                 off_is_reg,
    output logic [W-1:0]         eff_off,
    output logic [$clog2(W)-1:0] reg_idx
);
    import bitstr_pkg::*;

    localparam int NSZ   = 3;
    localparam int IDX_W = $clog2(W);

    logic [W-1:0] sext_v [NSZ];
    logic [W-1:0] mask_v [NSZ];
    logic [W-1:0] sext_sel;
    logic [W-1:0] mask_sel;

    // One signed view and one wrapped view per supported operand size.
    for (genvar g = 0; g < NSZ; g++) begin : g_size
        localparam int SZ = 16 << g;
        if (SZ < W) begin : g_narrow
            assign sext_v[g] = {{(W-SZ){offset[SZ-1]}}, offset[SZ-1:0]};
        end else begin : g_full
            assign sext_v[g] = offset;
        end
        assign mask_v[g] = offset & (W'(SZ) - W'(1));
    end

    always_comb begin
        sext_sel = sext_v[size_slot(size_sel)];
        mask_sel = mask_v[size_slot(size_sel)];
        eff_off  = off_is_reg ? sext_sel : mask_sel;
        reg_idx  = mask_sel[IDX_W-1:0];
    end
endmodule

// File: rtl/bitstr_reg_pick.sv
module bitstr_reg_pick #(
    parameter int W = 64
) (
    input  logic [W-1:0]         value,
    input  logic [$clog2(W)-1:0] idx,
    output logic                 bit_sel
);
    always_comb bit_sel = value[idx];
endmodule

// File: rtl/bitstr_mem_addr.sv
module bitstr_mem_addr #(
    parameter int W = 64
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] eff_off,
    output logic [W-1:0] byte_addr,
    output logic [2:0]   bit_idx
);
    logic signed [W-1:0] disp;

    // Arithmetic shift = division rounded toward minus infinity;
    // the low three bits are the non-negative remainder.
    always_comb begin
        disp      = $signed(eff_off) >>> 3;
        byte_addr = base + W'(disp);
        bit_idx   = eff_off[2:0];
    end
endmodule

// File: rtl/bitstr_ctrl.sv
module bitstr_ctrl #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         base_is_mem,
    input  logic         reg_bit,
    input  logic [W-1:0] mem_addr,
    input  logic [2:0]   mem_idx,
    input  logic         rd_valid,
    input  logic [7:0]   rd_byte,
    output logic         req_valid,
    output logic [W-1:0] req_addr,
    output logic         bit_valid,
    output logic         bit_out
);
    import bitstr_pkg::*;

    bsl_state_e   state, state_nx;
    logic [W-1:0] addr_q;
    logic [2:0]   idx_q;
    logic         bit_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // Transitions: T_ACCEPT_REG, T_ACCEPT_MEM, T_FILL, T_RETIRE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = base_is_mem ? ST_FETCH : ST_RESULT;
            ST_FETCH:  if (rd_valid) state_nx = ST_RESULT;
            ST_RESULT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Data captured on acceptance and on fill
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            idx_q  <= '0;
            bit_q  <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                if (base_is_mem) begin
                    addr_q <= mem_addr;
                    idx_q  <= mem_idx;
                end else begin
                    bit_q  <= reg_bit;
                end
            end
            if (state == ST_FETCH && rd_valid) bit_q <= rd_byte[idx_q];
        end
    end

    // Outputs
    always_comb begin
        req_valid = (state == ST_FETCH);
        req_addr  = addr_q;
        bit_valid = (state == ST_RESULT);
        bit_out   = (state == ST_RESULT) ? bit_q : 1'b0;
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> !req_valid && !bit_valid);

    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid && !rd_valid |=> req_valid && $stable(req_addr));

    p_fill_result_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid && rd_valid |=> bit_valid && !req_valid);

    p_idle_rd_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        !req_valid && !bit_valid && !start && rd_valid |=> !bit_valid && !req_valid);

    p_bit_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> !bit_valid);

    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && bit_valid));
endmodule

// File: rtl/bitstr_locator.sv
module bitstr_locator #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] base,
    input  logic [W-1:0] offset,
    input  logic [1:0]   size_sel,
    input  logic         off_is_reg,
    input  logic         base_is_mem,
    output logic         req_valid,
    output logic [W-1:0] req_addr,
    input  logic         rd_valid,
    input  logic [7:0]   rd_byte,
    output logic         bit_valid,
    output logic         bit_out
);
    localparam int IDX_W = $clog2(W);

    logic [W-1:0]     eff_off;
    logic [IDX_W-1:0] reg_idx;
    logic             reg_bit;
    logic [W-1:0]     mem_addr;
    logic [2:0]       mem_idx;

    bitstr_offset_norm #(.W(W)) u_norm (
        .offset     (offset),
        .size_sel   (size_sel),
        .off_is_reg (off_is_reg),
        .eff_off    (eff_off),
        .reg_idx    (reg_idx)
    );

    bitstr_reg_pick #(.W(W)) u_pick (
        .value   (base),
        .idx     (reg_idx),
        .bit_sel (reg_bit)
    );

    bitstr_mem_addr #(.W(W)) u_addr (
        .base      (base),
        .eff_off   (eff_off),
        .byte_addr (mem_addr),
        .bit_idx   (mem_idx)
    );

    bitstr_ctrl #(.W(W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .base_is_mem (base_is_mem),
        .reg_bit     (reg_bit),
        .mem_addr    (mem_addr),
        .mem_idx     (mem_idx),
        .rd_valid    (rd_valid),
        .rd_byte     (rd_byte),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .bit_valid   (bit_valid),
        .bit_out     (bit_out)
    );
endmodule

// File: tb/test_bitstr_locator.sv
`timescale 1ns/1ps
module test_bitstr_locator;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] base = '0;
    logic [W-1:0] offset = '0;
    logic [1:0]   size_sel = 2'b10;
    logic         off_is_reg = 1'b0;
    logic         base_is_mem = 1'b0;
    logic         req_valid;
    logic [W-1:0] req_addr;
    logic         rd_valid = 1'b0;
    logic [7:0]   rd_byte = '0;
    logic         bit_valid;
    logic         bit_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    bitstr_locator #(.W(W)) i_bitstr_locator (
        .clk, .rst, .start, .base, .offset, .size_sel, .off_is_reg,
        .base_is_mem, .req_valid, .req_addr, .rd_valid, .rd_byte,
        .bit_valid, .bit_out
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic reg_op(input logic [W-1:0] b, input logic [W-1:0] o,
                          input logic [1:0] sz, input logic exp_bit, input string req);
        base = b; offset = o; size_sel = sz; off_is_reg = 1'b1; base_is_mem = 1'b0;
        start = 1'b1;
        tick();
        start = 1'b0;
        check({req, " valid"}, W'(bit_valid), W'(1));
        check({req, " bit"}, W'(bit_out), W'(exp_bit));
        tick();
        check("R9 pulse ends", W'(bit_valid), W'(0));
    endtask

    task automatic mem_op(input logic [W-1:0] b, input logic [W-1:0] o, input logic [1:0] sz,
                          input logic isreg, input logic [7:0] dat,
                          input logic [W-1:0] exp_addr, input logic exp_bit, input string req);
        base = b; offset = o; size_sel = sz; off_is_reg = isreg; base_is_mem = 1'b1;
        start = 1'b1;
        tick();
        start = 1'b0;
        base = '0; offset = '0;
        check({req, " req_valid"}, W'(req_valid), W'(1));
        check({req, " addr"}, req_addr, exp_addr);
        tick();
        tick();
        check("R6 held", W'(req_valid), W'(1));
        check("R6 addr stable", req_addr, exp_addr);
        rd_valid = 1'b1; rd_byte = dat;
        tick();
        rd_valid = 1'b0; rd_byte = '0;
        check({req, " result valid"}, W'(bit_valid), W'(1));
        check({req, " bit"}, W'(bit_out), W'(exp_bit));
        check("R9 exclusive", W'(req_valid), W'(0));
        tick();
        check("R9 pulse ends", W'(bit_valid), W'(0));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        check("R1 req_valid after reset", W'(req_valid), W'(0));
        check("R1 bit_valid after reset", W'(bit_valid), W'(0));
    endtask

    task automatic t_reg_base();
        reg_op(64'h0000_0000_0020_0000, 64'd21, 2'b10, 1'b1, "R2 bit21 w64");
        reg_op(64'h0000_0000_0020_0000, 64'd20, 2'b10, 1'b0, "R2 bit20 w64");
        reg_op(64'h0000_0000_0000_8000, 64'd15, 2'b00, 1'b1, "R2 bit15 w16");
        reg_op(64'h8000_0000_0000_0000, 64'd63, 2'b11, 1'b1, "R2 bit63 sel11");
    endtask

    task automatic t_reg_wrap();
        reg_op(64'h20, 64'd37, 2'b01, 1'b1, "R3 37 mod 32");
        reg_op(64'h20, 64'd36, 2'b01, 1'b0, "R3 36 mod 32");
        reg_op(64'h20, 64'd21, 2'b00, 1'b1, "R3 21 mod 16");
        reg_op(64'h1,  64'd64, 2'b10, 1'b1, "R3 64 mod 64");
    endtask

    task automatic t_mem_imm();
        mem_op(64'h1000, 64'd13, 2'b00, 1'b0, 8'h20, 64'h1001, 1'b1, "R4 imm 13");
        mem_op(64'h1000, 64'd45, 2'b01, 1'b0, 8'hDF, 64'h1001, 1'b0, "R4 imm 45 mod 32");
        mem_op(64'h1000, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 1'b0, 8'h80, 64'h1001, 1'b1, "R4 imm mask 15");
    endtask

    task automatic t_mem_signed();
        mem_op(64'h1000, -64'sd11, 2'b10, 1'b1, 8'h20, 64'h0FFE, 1'b1, "R5 -11 w64");
        mem_op(64'h1000, 64'h0000_0000_0000_FFF5, 2'b00, 1'b1, 8'h20, 64'h0FFE, 1'b1, "R5 -11 w16");
        mem_op(64'h1000, -64'sd8, 2'b10, 1'b1, 8'h01, 64'h0FFF, 1'b1, "R5 -8");
        mem_op(64'h1000, 64'h0000_0000_FFFF_FFFF, 2'b01, 1'b1, 8'h80, 64'h0FFF, 1'b1, "R5 -1 w32");
        mem_op(64'h1000, 64'd13, 2'b01, 1'b1, 8'h20, 64'h1001, 1'b1, "R5 +13");
        mem_op(64'h1000, 64'h0000_0000_7FFF_FFFF, 2'b01, 1'b1, 8'h7F, 64'h1000_0FFF, 1'b0, "R5 max w32");
        mem_op(64'h1000, 64'h0000_0000_0000_8000, 2'b00, 1'b1, 8'h01, 64'h0000, 1'b1, "R5 min w16");
    endtask

    task automatic t_start_ignored();
        base = 64'h2000; offset = 64'd9; size_sel = 2'b10; off_is_reg = 1'b0; base_is_mem = 1'b1;
        start = 1'b1;
        tick();
        base = 64'h0000_0000_0000_FFFF; offset = 64'd0; base_is_mem = 1'b0; // start kept high
        tick();
        start = 1'b0;
        check("R7 no result mid-fetch", W'(bit_valid), W'(0));
        check("R7 addr unchanged", req_addr, 64'h2001);
        rd_valid = 1'b1; rd_byte = 8'h02;
        tick();
        rd_valid = 1'b0;
        check("R7 result from first op", W'(bit_out), W'(1));
        start = 1'b1; base_is_mem = 1'b1; base = 64'h3000;
        tick();
        start = 1'b0;
        check("R7 start in result cycle ignored", W'(req_valid), W'(0));
        tick();
    endtask

    task automatic t_idle_rd();
        rd_valid = 1'b1; rd_byte = 8'hFF;
        tick();
        rd_valid = 1'b0;
        check("R8 no bit_valid", W'(bit_valid), W'(0));
        check("R8 no request", W'(req_valid), W'(0));
    endtask

    task automatic t_reset_abort();
        base = 64'h4000; offset = 64'd3; size_sel = 2'b10; off_is_reg = 1'b0; base_is_mem = 1'b1;
        start = 1'b1;
        tick();
        start = 1'b0;
        check("R1 request opened", W'(req_valid), W'(1));
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check("R1 fetch abandoned", W'(req_valid), W'(0));
        rd_valid = 1'b1; rd_byte = 8'hFF;
        tick();
        rd_valid = 1'b0;
        check("R1 no late result", W'(bit_valid), W'(0));
    endtask

    initial begin
        #(8 * 20000);
        n_fail++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        tick();
        t_reset();
        t_reg_base();
        t_reg_wrap();
        t_mem_imm();
        t_mem_signed();
        t_start_ignored();
        t_idle_rd();
        t_reset_abort();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule